// File: doc/BRIEF.md
# Code Block Cache Controller

This controller sits between a processor's instruction fetch port and an off-chip memory that is good at long bursts but slow to answer. On-chip instruction storage is a fixed number of equal-sized SRAM blocks. Each block holds one link-time group of functions, and the group is always loaded and evicted as a whole. A small status table keeps, for every block, a valid bit and the off-chip block address the block currently mirrors. Every fetch address is compared against all table entries at once.

When a fetch hits, the word is read from SRAM and returned one cycle later. When it misses, the fetch stalls and a victim block is chosen. The victim's entry is invalidated and retargeted, and a burst engine copies the whole block from off-chip memory into it. Only after the final beat has been written is the entry marked valid. The stalled fetch then looks up again, now hits, and is served.

The replacement policy is a parameter: least recently used, or round robin. A block is the unit of allocation, so there is no tag/set array and no line fill.

The controller is a three-state machine:
- CB_IDLE looks up a pending fetch.
  - The hit transition goes to CB_RESP.
  - The miss transition goes to CB_FILL and starts the burst engine.
- CB_FILL waits for the engine.
  - The last-beat transition returns to CB_IDLE with the entry now valid.
- CB_RESP presents the word for one cycle.
  - The served transition returns to CB_IDLE.

The requester holds `fetch_req` and `fetch_addr` steady until it sees `fetch_ready`, and drops `fetch_req` in that cycle. On the memory side, one command of `mem_addr` is held on `mem_req` until `mem_ack`. BURST beats then arrive on `mem_rvalid`/`mem_rdata`, possibly with gaps.

Top module: `codeblk_cache`

## Requirements
- R1: After reset every table entry is invalid, `fetch_ready` and `mem_req` are low, and the first fetch of any address is a miss.
- R2: A fetch whose address lies in a valid block (same address bits above the low log2(BLK_WORDS) offset bits) raises `fetch_ready` in the cycle after the request is seen in CB_IDLE. It returns the word at that offset and issues no memory command.
- R3: On a miss, `fetch_ready` stays low until the refill of the whole block is complete.
- R4: A refill reads the block whose base is the fetch address with the low log2(BLK_WORDS) bits cleared. It does so with exactly BLK_WORDS/BURST commands at base + k*BURST (k = 0,1,...), each held until acknowledged and each followed by BURST beats.
- R5: The stalled fetch is served only after the final beat has been written. Every word of a refilled block then reads back as the off-chip word at the same offset.
- R6: With POLICY = 0 (LRU), the victim is the block least recently hit or refilled. After reset the order is block 0 least recent, then 1, 2 and onward.
- R7: With POLICY = 1 (round robin), victims are taken in the order 0, 1, ..., NBLK-1, 0, ... regardless of hits.
- R8: A given off-chip block is resident in at most one table entry at any time.
- R9: Block counts that are not a power of two (default NBLK = 6) are fully usable: all NBLK blocks are filled before any eviction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Fetch request, held until fetch_ready |
| fetch_addr | input | ADDR_W | Word address of the fetch in the off-chip image |
| fetch_ready | output | 1 | One-cycle pulse: fetch_data is valid |
| fetch_data | output | WORD_W | Fetched instruction word |
| mem_req | output | 1 | Burst command valid, held until mem_ack |
| mem_addr | output | ADDR_W | First word address of the burst |
| mem_ack | input | 1 | Memory accepts the command |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | WORD_W | Read beat data |

## Verification
The bench drives an LRU and a round-robin instance with the same fetch stream. It predicts every hit and miss from a reference model of both policies.

The directed part first fills all six blocks and re-touches the oldest one. It then forces one eviction where the two policies must disagree. A design with the wrong victim choice, or with LRU order not updated on hits, shows up as a hit where a miss was due, or the reverse.

Refills are fed with random acknowledge delays and beat gaps. Serving before the last beat, a wrong burst address, or a missing burst each give a wrong word or a wrong command count. Reading every word of a block, plus the highest address in the image, catches offset and alignment slips.

// File: rtl/cbc_pkg.sv
`timescale 1ns/1ps
package cbc_pkg;
    typedef enum logic [1:0] {
        CB_IDLE = 2'd0,
        CB_FILL = 2'd1,
        CB_RESP = 2'd2
    } cb_state_t;

    localparam int CB_POL_LRU = 0;
    localparam int CB_POL_RR  = 1;
endpackage

// File: rtl/cbc_lookup.sv
`timescale 1ns/1ps
// Parallel compare of the fetch block address against every table entry.
module cbc_lookup #(
    parameter int NBLK  = 6,
    parameter int TAG_W = 12,
    localparam int IDX_W = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NBLK-1:0]             ent_valid,
    input  logic [NBLK-1:0][TAG_W-1:0]  ent_tag,
    input  logic [TAG_W-1:0]            probe_tag,
    output logic                        hit,
    output logic [IDX_W-1:0]            hit_idx
);
    logic [NBLK-1:0] match;

    for (genvar g = 0; g < NBLK; g++) begin : g_cmp
        assign match[g] = ent_valid[g] && (ent_tag[g] == probe_tag);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < NBLK; i++) begin
            if (match[i]) hit_idx = hit_idx | IDX_W'(i);
        end
    end

    assign hit = |match;

    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match)); // R8
endmodule

// File: rtl/cbc_victim.sv
`timescale 1ns/1ps
// Victim selection: LRU rank table or round-robin pointer, chosen by POLICY.
module cbc_victim
    import cbc_pkg::*;
#(
    parameter int NBLK   = 6,
    parameter int POLICY = CB_POL_LRU,
    localparam int IDX_W = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic             advance,
    output logic [IDX_W-1:0] victim_idx
);
    if (POLICY == CB_POL_LRU) begin : g_lru
        logic [NBLK-1:0][IDX_W-1:0] rank;
        logic [NBLK-1:0]            is_oldest;
        logic                       lru_unused;

        assign lru_unused = advance;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < NBLK; i++) rank[i] <= IDX_W'(i);
            end else if (touch) begin
                for (int i = 0; i < NBLK; i++) begin
                    if (IDX_W'(i) == touch_idx)
                        rank[i] <= IDX_W'(NBLK - 1);
                    else if (rank[i] > rank[touch_idx])
                        rank[i] <= rank[i] - IDX_W'(1);
                end
            end
        end

        always_comb begin
            victim_idx = '0;
            for (int i = 0; i < NBLK; i++) begin
                is_oldest[i] = (rank[i] == '0);
                if (is_oldest[i]) victim_idx = IDX_W'(i);
            end
        end

        AST_LRU_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n) $countones(is_oldest) == 1); // R6
        AST_LRU_TOUCH_MRU: assert property (@(posedge clk) disable iff (!rst_n) touch |=> rank[$past(touch_idx)] == IDX_W'(NBLK - 1)); // R6
    end else begin : g_rr
        logic [IDX_W-1:0] ptr;
        logic             rr_unused;

        assign rr_unused = touch ^ (|touch_idx);

        always_ff @(posedge clk) begin
            if (!rst_n)
                ptr <= '0;
            else if (advance)
                ptr <= (ptr == IDX_W'(NBLK - 1)) ? '0 : ptr + IDX_W'(1);
        end

        assign victim_idx = ptr;

        AST_RR_STEP: assert property (@(posedge clk) disable iff (!rst_n) advance |=> (ptr == $past(ptr) + IDX_W'(1)) || (ptr == '0 && $past(ptr) == IDX_W'(NBLK - 1))); // R7
    end
endmodule

// File: rtl/cbc_dma.sv
`timescale 1ns/1ps
// Burst sequencer: copies one whole block as BLK_WORDS/BURST read bursts.
module cbc_dma #(
    parameter int ADDR_W    = 16,
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 16,
    parameter int BURST     = 4,
    localparam int OFF_W    = $clog2(BLK_WORDS),
    localparam int BT_W     = (BURST > 1) ? $clog2(BURST) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              wr_en,
    output logic [OFF_W-1:0]  wr_off,
    output logic [WORD_W-1:0] wr_data,
    output logic              done
);
    logic              busy;
    logic [OFF_W-1:0]  cnt;
    logic [BT_W-1:0]   beat;
    logic [ADDR_W-1:0] base_r;
    logic              last_word;
    logic              last_beat;

    assign wr_en     = busy && mem_rvalid && !mem_req;
    assign wr_off    = cnt;
    assign wr_data   = mem_rdata;
    assign last_word = (cnt == OFF_W'(BLK_WORDS - 1));
    assign last_beat = (beat == BT_W'(BURST - 1));
    assign done      = wr_en && last_word;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cnt      <= '0;
            beat     <= '0;
            base_r   <= '0;
            mem_req  <= 1'b0;
            mem_addr <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            cnt      <= '0;
            beat     <= '0;
            base_r   <= base;
            mem_req  <= 1'b1;
            mem_addr <= base;
        end else if (mem_req) begin
            if (mem_ack) mem_req <= 1'b0;
        end else if (wr_en) begin
            cnt <= cnt + OFF_W'(1);
            if (last_word) begin
                busy <= 1'b0;
            end else if (last_beat) begin
                beat     <= '0;
                mem_req  <= 1'b1;
                mem_addr <= base_r + ADDR_W'(cnt) + ADDR_W'(1);
            end else begin
                beat <= beat + BT_W'(1);
            end
        end
    end

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R4
    AST_CMD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> ((mem_addr - base_r) % ADDR_W'(BURST)) == '0); // R4
endmodule

// File: rtl/cbc_store.sv
`timescale 1ns/1ps
// Plain SRAM holding NBLK blocks of BLK_WORDS words, registered read port.
module cbc_store #(
    parameter int NBLK      = 6,
    parameter int BLK_WORDS = 16,
    parameter int WORD_W    = 32,
    localparam int IDX_W    = (NBLK > 1) ? $clog2(NBLK) : 1,
    localparam int OFF_W    = $clog2(BLK_WORDS),
    localparam int DEPTH    = NBLK * BLK_WORDS,
    localparam int SA_W     = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  wblk,
    input  logic [OFF_W-1:0]  woff,
    input  logic [WORD_W-1:0] wdata,
    input  logic              re,
    input  logic [IDX_W-1:0]  rblk,
    input  logic [OFF_W-1:0]  roff,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [SA_W-1:0]   wa;
    logic [SA_W-1:0]   ra;

    assign wa = SA_W'(wblk) * SA_W'(BLK_WORDS) + SA_W'(woff);
    assign ra = SA_W'(rblk) * SA_W'(BLK_WORDS) + SA_W'(roff);

    always_ff @(posedge clk) begin
        if (we) mem[wa] <= wdata;
        if (re) rdata <= mem[ra];
    end
endmodule

// File: rtl/codeblk_cache.sv
`timescale 1ns/1ps
module codeblk_cache
    import cbc_pkg::*;
#(
    parameter int NBLK      = 6,
    parameter int BLK_WORDS = 16,
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 16,
    parameter int BURST     = 4,
    parameter int POLICY    = CB_POL_LRU
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ready,
    output logic [WORD_W-1:0] fetch_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam int OFF_W = $clog2(BLK_WORDS);
    localparam int TAG_W = ADDR_W - OFF_W;
    localparam int IDX_W = (NBLK > 1) ? $clog2(NBLK) : 1;

    cb_state_t state_q, state_d;

    logic [NBLK-1:0]            tbl_val;
    logic [NBLK-1:0][TAG_W-1:0] tbl_tag;
    logic [IDX_W-1:0]           fill_idx;

    logic [TAG_W-1:0]  fetch_tag;
    logic [OFF_W-1:0]  fetch_off;
    logic              hit;
    logic [IDX_W-1:0]  hit_idx;
    logic [IDX_W-1:0]  victim_idx;
    logic              start_fill;
    logic              rd_en;
    logic              touch;
    logic [IDX_W-1:0]  touch_idx;
    logic              dma_wr;
    logic [OFF_W-1:0]  dma_off;
    logic [WORD_W-1:0] dma_data;
    logic              dma_done;

    assign fetch_tag = fetch_addr[ADDR_W-1:OFF_W];
    assign fetch_off = fetch_addr[OFF_W-1:0];

    cbc_lookup #(.NBLK(NBLK), .TAG_W(TAG_W)) u_lookup (
        .clk(clk), .rst_n(rst_n),
        .ent_valid(tbl_val), .ent_tag(tbl_tag), .probe_tag(fetch_tag),
        .hit(hit), .hit_idx(hit_idx)
    );

    cbc_victim #(.NBLK(NBLK), .POLICY(POLICY)) u_victim (
        .clk(clk), .rst_n(rst_n),
        .touch(touch), .touch_idx(touch_idx),
        .advance(start_fill), .victim_idx(victim_idx)
    );

    cbc_dma #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS), .BURST(BURST)) u_dma (
        .clk(clk), .rst_n(rst_n),
        .start(start_fill), .base({fetch_tag, {OFF_W{1'b0}}}),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .wr_en(dma_wr), .wr_off(dma_off), .wr_data(dma_data), .done(dma_done)
    );

    cbc_store #(.NBLK(NBLK), .BLK_WORDS(BLK_WORDS), .WORD_W(WORD_W)) u_store (
        .clk(clk),
        .we(dma_wr), .wblk(fill_idx), .woff(dma_off), .wdata(dma_data),
        .re(rd_en), .rblk(hit_idx), .roff(fetch_off), .rdata(fetch_data)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CB_IDLE;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d     = state_q;
        fetch_ready = 1'b0;
        start_fill  = 1'b0;
        rd_en       = 1'b0;
        touch       = 1'b0;
        touch_idx   = hit_idx;
        unique case (state_q)
            CB_IDLE: begin
                if (fetch_req && hit) begin
                    rd_en   = 1'b1;
                    touch   = 1'b1;
                    state_d = CB_RESP;
                end else if (fetch_req) begin
                    start_fill = 1'b1;
                    state_d    = CB_FILL;
                end
            end
            CB_FILL: begin
                touch_idx = fill_idx;
                if (dma_done) begin
                    touch   = 1'b1;
                    state_d = CB_IDLE;
                end
            end
            CB_RESP: begin
                fetch_ready = 1'b1;
                state_d     = CB_IDLE;
            end
            default: state_d = CB_IDLE;
        endcase
    end

    // Block status table
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_val  <= '0;
            tbl_tag  <= '0;
            fill_idx <= '0;
        end else if (start_fill) begin
            tbl_val[victim_idx] <= 1'b0;
            tbl_tag[victim_idx] <= fetch_tag;
            fill_idx            <= victim_idx;
        end else if (state_q == CB_FILL && dma_done) begin
            tbl_val[fill_idx] <= 1'b1;
        end
    end

    AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n) (state_q == CB_IDLE && fetch_req && hit) |=> (!mem_req && fetch_ready)); // R2
    AST_MISS_STARTS_DMA: assert property (@(posedge clk) disable iff (!rst_n) (state_q == CB_IDLE && fetch_req && !hit) |=> (mem_req && mem_addr == {$past(fetch_tag), {OFF_W{1'b0}}})); // R4
    AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n) (state_q == CB_FILL && dma_done) |=> (hit || !fetch_req)); // R5
    AST_NO_DMA_WRITE_OUT_OF_FILL: assert property (@(posedge clk) disable iff (!rst_n) dma_wr |-> (state_q == CB_FILL && !fetch_ready)); // R3
endmodule

// File: tb/sim_codeblk_cache.sv
`timescale 1ns/1ps
module sim_codeblk_cache;
    localparam int CLK_PERIOD = 10;
    localparam int NB   = 6;
    localparam int BW   = 16;
    localparam int BUR  = 4;
    localparam int AW   = 16;
    localparam int WW   = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          freq [2];
    logic [AW-1:0] faddr;
    logic          frdy [2];
    logic [WW-1:0] fdata [2];
    logic          mreq [2];
    logic [AW-1:0] maddr [2];
    logic          mack [2];
    logic          mrv [2];
    logic [WW-1:0] mrd [2];

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    int mtag  [2][NB];
    bit mval  [2][NB];
    int mrank [2][NB];
    int mrr   [2];
    int exp_base [2];
    int nb [2];
    int nbeat [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [WW-1:0] mword(logic [AW-1:0] a);
        return {a, ~a ^ 16'h3C5A};
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    for (genvar k = 0; k < 2; k++) begin : g_dut
        codeblk_cache #(.NBLK(NB), .BLK_WORDS(BW), .WORD_W(WW), .ADDR_W(AW), .BURST(BUR), .POLICY(k)) u0 (
            .clk(clk), .rst_n(rst_n),
            .fetch_req(freq[k]), .fetch_addr(faddr),
            .fetch_ready(frdy[k]), .fetch_data(fdata[k]),
            .mem_req(mreq[k]), .mem_addr(maddr[k]), .mem_ack(mack[k]),
            .mem_rvalid(mrv[k]), .mem_rdata(mrd[k])
        );

        // Off-chip burst memory model
        initial begin
            logic [AW-1:0] a;
            mack[k] = 1'b0; mrv[k] = 1'b0; mrd[k] = '0;
            forever begin
                @(negedge clk);
                if (rst_n && mreq[k]) begin
                    repeat ($urandom_range(0, 2)) @(negedge clk);
                    a = maddr[k];
                    // R4: command address is base + k*BURST
                    check(int'(a) == exp_base[k] + nb[k] * BUR, "R4 burst address", a, exp_base[k] + nb[k] * BUR);
                    nb[k]++;
                    mack[k] = 1'b1;
                    @(negedge clk);
                    mack[k] = 1'b0;
                    for (int b = 0; b < BUR; b++) begin
                        repeat ($urandom_range(0, 1)) @(negedge clk);
                        mrv[k] = 1'b1;
                        mrd[k] = mword(a + AW'(b));
                        nbeat[k]++;
                        @(negedge clk);
                        mrv[k] = 1'b0;
                    end
                end
            end
        end
    end

    function automatic int m_find(int k, int tag);
        for (int i = 0; i < NB; i++) if (mval[k][i] && mtag[k][i] == tag) return i;
        return -1;
    endfunction

    function automatic void m_touch(int k, int idx);
        int r = mrank[k][idx];
        for (int j = 0; j < NB; j++) if (mrank[k][j] > r) mrank[k][j]--;
        mrank[k][idx] = NB - 1;
    endfunction

    function automatic int m_victim(int k);
        if (k == 1) return mrr[k];
        for (int i = 0; i < NB; i++) if (mrank[k][i] == 0) return i;
        return 0;
    endfunction

    task automatic fetch(logic [AW-1:0] addr);
        bit hitp [2];
        bit seen [2];
        int cyc;
        int tag = int'(addr) / BW;
        for (int k = 0; k < 2; k++) begin
            int p = m_find(k, tag);
            hitp[k] = (p >= 0);
            seen[k] = 0;
            nb[k] = 0;
            nbeat[k] = 0;
            exp_base[k] = tag * BW;
            if (hitp[k]) m_touch(k, p);
            else begin
                int v = m_victim(k);
                mval[k][v] = 1;
                mtag[k][v] = tag;
                m_touch(k, v);
                mrr[k] = (mrr[k] + 1) % NB;
            end
        end
        faddr = addr;
        freq[0] = 1'b1;
        freq[1] = 1'b1;
        cyc = 0;
        while (!(seen[0] && seen[1])) begin
            @(negedge clk);
            cyc++;
            for (int k = 0; k < 2; k++) begin
                if (freq[k] && frdy[k]) begin
                    bit obs_hit = (cyc == 1) && (nb[k] == 0);
                    seen[k] = 1;
                    freq[k] = 1'b0;
                    // R6 (LRU) / R7 (round robin) / R2: hit or miss as predicted
                    check(obs_hit == hitp[k], (k == 0) ? "R6 R2 hit/miss vs LRU model" : "R7 R2 hit/miss vs RR model", obs_hit, hitp[k]);
                    // R3 R4 R5: miss served only after the full block was burst in
                    if (!hitp[k])
                        check(nb[k] == BW / BUR && nbeat[k] == BW, "R3 R5 served after full refill", nbeat[k], BW);
                    check(fdata[k] == mword(addr), "R5 R2 fetched word", fdata[k], mword(addr));
                end
            end
        end
        @(negedge clk);
    endtask

    initial begin
        for (int k = 0; k < 2; k++) begin
            freq[k] = 1'b0;
            mrr[k] = 0;
            for (int i = 0; i < NB; i++) begin
                mval[k][i] = 0; mtag[k][i] = 0; mrank[k][i] = i;
            end
        end
        faddr = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int k = 0; k < 2; k++) begin
            check(frdy[k] == 1'b0, "R1 fetch_ready low after reset", frdy[k], 0);
            check(mreq[k] == 1'b0, "R1 mem_req low after reset", mreq[k], 0);
        end
        // R1: first fetch misses; then every word of the block hits (R5)
        fetch(16'h0003);
        for (int w = 0; w < BW; w++) fetch(AW'(w));
        // R9: fill all six blocks before any eviction
        for (int t = 1; t < NB; t++) fetch(AW'(t * BW + t));
        for (int t = 0; t < NB; t++) fetch(AW'(t * BW + BW - 1));
        // make block address 0 most recent, then force an eviction: R6 vs R7 diverge
        fetch(16'h0007);
        fetch(AW'(6 * BW + 2));
        fetch(16'h0009);
        fetch(AW'(1 * BW + 4));
        // highest address in the image
        fetch(16'hFFFF);
        fetch(16'hFFF0);
        // constrained random mix
        for (int n = 0; n < 250; n++) begin
            int t = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 4095)) : int'($urandom_range(0, 8));
            fetch(AW'(t * BW + int'($urandom_range(0, BW - 1))));
        end
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule